// File: doc/BRIEF.md
# ISA-Style Bus Cycle Master

This block runs single 8-bit read and write transfers on a time-multiplexed parallel bus that separates memory space from I/O space. A host hands it one request at a time: the access kind, an address and, for writes, a data byte. The block then sequences the bus through a fixed four-clock cycle. The first clock pulses an address-latch strobe with the address on the bus. The second clock asserts the active-low command strobe for the access kind and starts the write data. A third clock finishes the command. A final clock returns every strobe high. Memory accesses carry a 20-bit address. I/O accesses carry a 16-bit address, and the upper address lines are driven low.

A slow slave stretches the cycle by holding its ready input low. The master samples ready at the end of the second clock and at the end of every wait clock it adds. It inserts wait clocks while ready stays low, up to six. If ready is still low after the sixth wait clock, the master completes the cycle anyway and reports a timeout. Read data is captured on the last command clock. The captured byte and the timeout flag come back with a one-clock done pulse.

The request port follows valid/ready rules. A request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` is high only while no cycle is in progress, so the host must keep its request stable until it is taken. The done pulse, the timeout flag and the returned read byte are plain status signals. They have no back-pressure.

Top module: `bus_cycle_master`

## Requirements
- R1: While in reset and right after it, all four command strobes are high, the address-latch strobe and done are low, and `req_ready_o` is high.
- R2: A request is accepted on a clock edge with `req_valid_i` and `req_ready_o` both high. `req_ready_o` then stays low for the whole bus cycle and is high again in the clock where done is high.
- R3: The address-latch strobe is high for exactly one clock, the first clock after acceptance. All command strobes are high during it.
- R4: `bus_addr_o` carries the request address from the first clock through the last clock of the cycle. For I/O kinds only the low 16 bits are passed, and bits 19:16 are zero.
- R5: `req_kind_i` bit 1 selects I/O (1) or memory (0), and bit 0 selects write (1) or read (0). Kinds 0, 1, 2 and 3 drive `mem_rd_n_o`, `mem_wr_n_o`, `io_rd_n_o` and `io_wr_n_o` low respectively. The other three strobes stay high.
- R6: The selected strobe goes low in the second clock and stays low through the end of the third phase, for 2+w clocks where w is the number of wait clocks. It is high in the final clock.
- R7: `slave_rdy_i` is sampled at the end of the second clock and at the end of each wait clock. Each low sample adds one wait clock, so the cycle takes 4+w clocks from acceptance to the final clock.
- R8: No more than 6 wait clocks are inserted. If ready is still low at the end of the sixth wait clock, the cycle completes and `timeout_o` is high together with done. Otherwise `timeout_o` is low with done.
- R9: For write kinds, `bus_wdata_oe_o` is high and `bus_wdata_o` carries the write byte from the second clock through the final clock, for 3+w clocks. For read kinds the enable stays low.
- R10: `rd_data_o` holds the value of `bus_rdata_i` sampled on the last command clock of a read. `done_o` is a one-clock pulse in the clock that follows the final clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Master idle; request taken when valid is also high |
| req_kind_i | input | 2 | Access kind: bit 1 = I/O, bit 0 = write |
| req_addr_i | input | 20 | Request address |
| req_wdata_i | input | 8 | Write byte |
| done_o | output | 1 | One-clock pulse when the cycle has finished |
| timeout_o | output | 1 | Ready was still low after the last wait clock (valid with done) |
| rd_data_o | output | 8 | Byte captured by the last read |
| bus_addr_latch_o | output | 1 | Address-latch strobe, high in the first clock |
| bus_addr_o | output | 20 | Bus address lines |
| bus_wdata_o | output | 8 | Bus data driven by the master |
| bus_wdata_oe_o | output | 1 | Master drives the data lines |
| bus_rdata_i | input | 8 | Bus data returned by the slave |
| slave_rdy_i | input | 1 | Slave ready; low adds wait clocks |
| mem_rd_n_o | output | 1 | Memory read strobe, active low |
| mem_wr_n_o | output | 1 | Memory write strobe, active low |
| io_rd_n_o | output | 1 | I/O read strobe, active low |
| io_wr_n_o | output | 1 | I/O write strobe, active low |

## Verification
The bench runs every access kind against a slave that holds ready low for each count from 0 to 8 clocks. Each run uses a different address and data byte. Hold counts 0 to 6 show that each low sample adds exactly one wait clock. Count 6 shows that ready rising on the last permitted sample still avoids a timeout, and counts 7 and 8 show the cap and the timeout flag. The slave presents valid read data only once it is ready, so a capture taken too early returns zero instead of the expected byte. Pairs of kinds that share a space or a direction separate the strobe decode from the address masking of I/O accesses.

// File: rtl/bus_cycle_pkg.sv
package bus_cycle_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_C1   = 3'd1,
    PH_C2   = 3'd2,
    PH_WAIT = 3'd3,
    PH_C3   = 3'd4,
    PH_C4   = 3'd5
  } phase_t;

  localparam int KIND_W = 2;
  localparam int KIND_N = 4;

  function automatic logic kind_is_io(input logic [KIND_W-1:0] k);
    return k[1];
  endfunction

  function automatic logic kind_is_write(input logic [KIND_W-1:0] k);
    return k[0];
  endfunction

  function automatic logic phase_cmd(input phase_t p);
    return (p == PH_C2) || (p == PH_WAIT) || (p == PH_C3);
  endfunction
endpackage

// File: rtl/bcm_sequencer.sv
module bcm_sequencer
  import bus_cycle_pkg::*;
#(
  parameter int MAX_WAIT = 6
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   slave_rdy,
  output phase_t phase,
  output logic   done,
  output logic   timeout
);
  localparam int CNT_W = $clog2(MAX_WAIT + 2);

  logic [CNT_W-1:0] wcnt;
  logic             late;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      wcnt    <= '0;
      late    <= 1'b0;
      done    <= 1'b0;
      timeout <= 1'b0;
    end else begin
      done    <= 1'b0;
      timeout <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (start) begin
            phase <= PH_C1;
            wcnt  <= '0;
            late  <= 1'b0;
          end
        end
        PH_C1: phase <= PH_C2;
        PH_C2: begin
          if (!slave_rdy && MAX_WAIT > 0) begin
            phase <= PH_WAIT;
            wcnt  <= CNT_W'(1);
          end else begin
            late  <= !slave_rdy;
            phase <= PH_C3;
          end
        end
        PH_WAIT: begin
          if (slave_rdy) begin
            phase <= PH_C3;
          end else if (wcnt == CNT_W'(MAX_WAIT)) begin
            late  <= 1'b1;
            phase <= PH_C3;
          end else begin
            wcnt <= wcnt + CNT_W'(1);
          end
        end
        PH_C3: phase <= PH_C4;
        PH_C4: begin
          phase   <= PH_IDLE;
          done    <= 1'b1;
          timeout <= late;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bcm_strobe_dec.sv
module bcm_strobe_dec
  import bus_cycle_pkg::*;
(
  input  phase_t             phase,
  input  logic [KIND_W-1:0]  kind,
  output logic [KIND_N-1:0]  strb_n,
  output logic               addr_latch,
  output logic               wdata_oe
);
  logic cmd_active;
  assign cmd_active = phase_cmd(phase);
  assign addr_latch = (phase == PH_C1);
  assign wdata_oe   = kind_is_write(kind) &&
                      (cmd_active || phase == PH_C4);

  for (genvar k = 0; k < KIND_N; k++) begin : g_strb
    assign strb_n[k] = !(cmd_active && kind == KIND_W'(k));
  end
endmodule

// File: rtl/bcm_datapath.sv
module bcm_datapath
  import bus_cycle_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int IO_ADDR_W = 16,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [KIND_W-1:0] req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [KIND_W-1:0] kind_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);
  logic [ADDR_W-1:0] addr_in;

  if (ADDR_W > IO_ADDR_W) begin : g_mask
    assign addr_in = kind_is_io(req_kind)
                   ? {{(ADDR_W-IO_ADDR_W){1'b0}}, req_addr[IO_ADDR_W-1:0]}
                   : req_addr;
  end else begin : g_nomask
    assign addr_in = req_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        kind_q  <= req_kind;
        addr_q  <= addr_in;
        wdata_q <= req_wdata;
      end
      if (capture) rdata_q <= bus_rdata;
    end
  end
endmodule

// File: rtl/bus_cycle_master.sv
module bus_cycle_master
  import bus_cycle_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int IO_ADDR_W = 16,
  parameter int DATA_W    = 8,
  parameter int MAX_WAIT  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_kind_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              done_o,
  output logic              timeout_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              bus_addr_latch_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              bus_wdata_oe_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              slave_rdy_i,
  output logic              mem_rd_n_o,
  output logic              mem_wr_n_o,
  output logic              io_rd_n_o,
  output logic              io_wr_n_o
);
  phase_t             phase;
  logic               accept;
  logic [KIND_W-1:0]  kind_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [KIND_N-1:0]  strb_n;
  logic               oe;

  assign req_ready_o = (phase == PH_IDLE);
  assign accept      = req_valid_i && req_ready_o;

  bcm_sequencer #(.MAX_WAIT(MAX_WAIT)) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .slave_rdy (slave_rdy_i),
    .phase     (phase),
    .done      (done_o),
    .timeout   (timeout_o)
  );

  bcm_datapath #(
    .ADDR_W    (ADDR_W),
    .IO_ADDR_W (IO_ADDR_W),
    .DATA_W    (DATA_W)
  ) i_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .req_kind  (req_kind_i),
    .req_addr  (req_addr_i),
    .req_wdata (req_wdata_i),
    .capture   (phase == PH_C3),
    .bus_rdata (bus_rdata_i),
    .kind_q    (kind_q),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q),
    .rdata_q   (rd_data_o)
  );

  bcm_strobe_dec i_dec (
    .phase      (phase),
    .kind       (kind_q),
    .strb_n     (strb_n),
    .addr_latch (bus_addr_latch_o),
    .wdata_oe   (oe)
  );

  assign bus_addr_o     = (phase == PH_IDLE) ? '0 : addr_q;
  assign bus_wdata_oe_o = oe;
  assign bus_wdata_o    = oe ? wdata_q : '0;
  assign mem_rd_n_o     = strb_n[0];
  assign mem_wr_n_o     = strb_n[1];
  assign io_rd_n_o      = strb_n[2];
  assign io_wr_n_o      = strb_n[3];
endmodule

// File: rtl/bcm_checker.sv
module bcm_checker #(
  parameter int ADDR_W    = 20,
  parameter int IO_ADDR_W = 16,
  parameter int MAX_WAIT  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready_o,
  input logic              done_o,
  input logic              bus_addr_latch_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              mem_rd_n_o,
  input logic              mem_wr_n_o,
  input logic              io_rd_n_o,
  input logic              io_wr_n_o
);
  logic [3:0] strb_low;
  logic [7:0] low_run;

  assign strb_low = {~io_wr_n_o, ~io_rd_n_o, ~mem_wr_n_o, ~mem_rd_n_o};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run <= '0;
    else if (strb_low != 4'b0) low_run <= (low_run == 8'hFF) ? low_run : low_run + 8'd1;
    else low_run <= '0;
  end

  // R5
  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(strb_low) <= 1);

  // R3
  a_r3_latch_single: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr_latch_o |=> !bus_addr_latch_o);

  // R3
  a_r3_no_cmd_at_latch: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr_latch_o |-> (strb_low == 4'b0));

  // R2
  a_r2_busy_in_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_low != 4'b0) |-> !req_ready_o);

  // R4
  a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ((strb_low != 4'b0) && $past(strb_low != 4'b0)) |-> $stable(bus_addr_o));

  // R8
  a_r8_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(low_run) <= MAX_WAIT + 2);

  // R10
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10
  a_r10_done_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (strb_low == 4'b0));

  if (ADDR_W > IO_ADDR_W) begin : g_io_chk
    // R4
    a_r4_io_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!io_rd_n_o || !io_wr_n_o) |-> (bus_addr_o[ADDR_W-1:IO_ADDR_W] == '0));
  end
endmodule

bind bus_cycle_master bcm_checker #(
  .ADDR_W    (ADDR_W),
  .IO_ADDR_W (IO_ADDR_W),
  .MAX_WAIT  (MAX_WAIT)
) i_bcm_checker (
  .clk              (clk),
  .rst_n            (rst_n),
  .req_ready_o      (req_ready_o),
  .done_o           (done_o),
  .bus_addr_latch_o (bus_addr_latch_o),
  .bus_addr_o       (bus_addr_o),
  .mem_rd_n_o       (mem_rd_n_o),
  .mem_wr_n_o       (mem_wr_n_o),
  .io_rd_n_o        (io_rd_n_o),
  .io_wr_n_o        (io_wr_n_o)
);

// File: tb/test_bus_cycle_master.sv
module test_bus_cycle_master;
  localparam int MAXW = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = 2'd0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        done, timeout;
  logic [7:0]  rd_data;
  logic        ale;
  logic [19:0] baddr;
  logic [7:0]  bwdata;
  logic        boe;
  logic [7:0]  brdata;
  logic        rdy;
  logic        mrd_n, mwr_n, iord_n, iowr_n;

  int checks = 0;
  int failures = 0;

  int         hold_n = 0;
  int         stall_cnt = 0;
  logic [7:0] slave_rd = '0;
  logic [3:0] low;

  always #5 clk = ~clk;

  bus_cycle_master i_bus_cycle_master (
    .clk (clk), .rst_n (rst_n),
    .req_valid_i (req_valid), .req_ready_o (req_ready),
    .req_kind_i (req_kind), .req_addr_i (req_addr), .req_wdata_i (req_wdata),
    .done_o (done), .timeout_o (timeout), .rd_data_o (rd_data),
    .bus_addr_latch_o (ale), .bus_addr_o (baddr),
    .bus_wdata_o (bwdata), .bus_wdata_oe_o (boe),
    .bus_rdata_i (brdata), .slave_rdy_i (rdy),
    .mem_rd_n_o (mrd_n), .mem_wr_n_o (mwr_n),
    .io_rd_n_o (iord_n), .io_wr_n_o (iowr_n)
  );

  // slave model: ready after hold_n command clocks, read data valid once ready
  assign low = {~iowr_n, ~iord_n, ~mwr_n, ~mrd_n};
  always @(posedge clk) begin
    if (low != 4'b0) stall_cnt <= stall_cnt + 1;
    else stall_cnt <= 0;
  end
  assign rdy = (stall_cnt >= hold_n);
  assign brdata = ((low[0] || low[2]) && (stall_cnt >= hold_n || stall_cnt >= MAXW + 1))
                ? slave_rd : 8'h00;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_xfer(input logic [1:0] k, input logic [19:0] a,
                         input logic [7:0] wd, input logic [7:0] rd, input int n);
    int w;
    logic to_exp;
    logic [19:0] a_exp;
    int cyc, ale_cnt, ale_at, addr_bad, low_cnt, low_first, wrong_cnt, right_cnt, oe_cnt, busy_bad;
    logic [7:0] wseen;
    logic to_seen;
    logic [7:0] rd_seen;
    logic ready_at_done;
    w = (n < MAXW) ? n : MAXW;
    to_exp = (n > MAXW);
    a_exp = k[1] ? {4'h0, a[15:0]} : a;
    hold_n = n;
    slave_rd = rd;
    @(negedge clk);
    chk(req_ready, "R2 ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd;
    cyc = 0; ale_cnt = 0; ale_at = 0; addr_bad = 0; low_cnt = 0; low_first = 0;
    wrong_cnt = 0; right_cnt = 0; oe_cnt = 0; busy_bad = 0; wseen = 8'h00;
    to_seen = 1'b0; rd_seen = 8'h00; ready_at_done = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      cyc++;
      if (done) begin
        to_seen = timeout; rd_seen = rd_data; ready_at_done = req_ready;
        break;
      end
      if (req_ready) busy_bad++;
      if (ale) begin ale_cnt++; ale_at = cyc; end
      if (baddr != a_exp) addr_bad++;
      if (low != 4'b0 && low_first == 0) low_first = cyc;
      if (low != 4'b0) low_cnt++;
      for (int s = 0; s < 4; s++) begin
        if (low[s] && s == int'(k)) right_cnt++;
        if (low[s] && s != int'(k)) wrong_cnt++;
      end
      if (boe) begin
        oe_cnt++;
        if (low[1] || low[3]) wseen = bwdata;
      end
    end
    chk(cyc == 5 + w, "R7 clocks to done", cyc, 5 + w);
    chk(busy_bad == 0, "R2 ready low during cycle", busy_bad, 0);
    chk(ready_at_done, "R2 ready with done", int'(ready_at_done), 1);
    chk(ale_cnt == 1 && ale_at == 1, "R3 latch pulse at first clock", ale_at, 1);
    chk(addr_bad == 0, "R4 address held", int'(baddr), int'(a_exp));
    chk(low_cnt == 2 + w && low_first == 2, "R6 strobe window", low_cnt, 2 + w);
    chk(wrong_cnt == 0 && right_cnt == 2 + w, "R5 strobe select", wrong_cnt, 0);
    chk(to_seen == to_exp, "R8 timeout flag", int'(to_seen), int'(to_exp));
    if (k[0]) begin
      chk(oe_cnt == 3 + w, "R9 write enable length", oe_cnt, 3 + w);
      chk(wseen == wd, "R9 write data", int'(wseen), int'(wd));
    end else begin
      chk(oe_cnt == 0, "R9 no enable on read", oe_cnt, 0);
      chk(rd_seen == rd, "R10 read data", int'(rd_seen), int'(rd));
    end
    @(negedge clk);
    chk(!done, "R10 done single clock", int'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mrd_n && mwr_n && iord_n && iowr_n, "R1 strobes high in reset", int'(low), 0);
    chk(!ale && !done && req_ready, "R1 idle outputs in reset", int'({ale, done, req_ready}), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(low == 4'b0 && !ale && !done && req_ready, "R1 idle after reset",
        int'({low, ale, done, req_ready}), 1);
    for (int k = 0; k < 4; k++) begin
      for (int n = 0; n <= MAXW + 2; n++) begin
        int idx;
        idx = k * (MAXW + 3) + n;
        do_xfer(2'(k), 20'(32'h9A5C3 + idx * 32'h1111),
                8'(idx * 37 + 5), 8'(idx * 53 + 11), n);
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule